// File: doc/BRIEF.md
# Security-Register Program Engine

This block is the device-side receiver for the command that writes one of three one-time-programmable security registers in a serial flash device. It watches a single-bit SPI link in a single system clock domain. It oversamples the serial clock, chip-select and data line, and it decodes the opcode. It then collects a 24-bit or 32-bit address and one or more data bytes. Each register is 256 bytes deep and is held inside the block.

The command counts only when several conditions hold. The write-enable status input must be high when the opcode completes. The address must name one of the three registers. The lock input for that register must be clear. Incoming bytes go into a staging buffer first, and the array is changed only after chip-select rises cleanly on a byte boundary. The engine then spends a fixed interval merging the staged bytes into the array, one byte per cycle. Programming can only clear bits. When the interval ends, the engine emits a one-cycle request to clear the write-enable latch. A read port lets the surrounding device logic see any byte of the three registers.

Top module: `secreg_prog_engine`

## Requirements
- R1: After reset every byte of all three registers reads 0xFF, `busy` is low and `wel_clr` is low.
- R2: Only opcode 0x42 starts a program command. It is received MSB first on rising serial-clock edges while chip-select is low, in both clock-idle-low and clock-idle-high framing. Any other opcode leaves the registers unchanged and causes no busy period.
- R3: A command whose opcode completes while `wel` is low is dropped. There is no array change, no busy period and no `wel_clr` pulse.
- R4: The address that follows the opcode is 24 bits MSB first when `addr4b` is low, and 32 bits when `addr4b` is high. `addr4b` is sampled when the opcode completes.
- R5: Address bits 15:12 select the register: value 1 selects `rd_sel`=0, 2 selects `rd_sel`=1 and 3 selects `rd_sel`=2. A command is dropped with no side effect if bits 15:12 hold any other value, if bits 11:8 are not zero, or if any bit above 15 is set.
- R6: Address bits 7:0 give the offset of the first data byte. Each later byte goes to the next offset, and the offset wraps from 255 to 0 inside the same register.
- R7: Each stored byte becomes its previous value ANDed with the received byte. Data bytes arrive MSB first.
- R8: When `lock[k]` is 1, a command addressed to register k (`rd_sel`=k) is dropped. Commands to the other registers are still accepted.
- R9: A command is committed only if chip-select rises after a whole number of data bytes, with at least one byte received. If chip-select rises after zero data bytes or part-way through a byte, nothing at all is written.
- R10: When more than 256 data bytes are sent, only the last 256 received are applied. Earlier bytes that landed on the same offsets have no effect.
- R11: A committed command raises `busy` for exactly 256 consecutive cycles. `wel_clr` is then high for exactly one cycle, the first cycle after `busy` falls.
- R12: A frame whose chip-select falls while `busy` is high is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_csn | input | 1 | Active-low chip-select |
| spi_di | input | 1 | Serial data in |
| wel | input | 1 | Write-enable latch state |
| addr4b | input | 1 | High selects 32-bit addressing |
| lock | input | 3 | Per-register lock, bit k guards register k |
| rd_sel | input | 2 | Register select for the read port |
| rd_idx | input | 8 | Byte offset for the read port |
| rd_data | output | 8 | Byte at the selected register and offset |
| busy | output | 1 | High while staged bytes are merged into the array |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The merge interval of one command can overlap the chip-select fall of the next frame. The block must then refuse the new frame and leave the staging buffer alone while it is still being read out. The bench provokes this by starting a second, fully valid frame a few cycles after the first one commits. It then checks for a single 256-cycle busy period and a single `wel_clr` pulse, and it checks that the arrays hold only the first frame's bytes. Another overlap is the staged-byte counter wrapping in the same cycle as a byte lands on an offset already written. This is judged with a 300-byte frame against a bench model that applies only the final 256 bytes.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_DROP
  } dec_state_t;

  localparam int          NUM_SECREGS  = 3;
  localparam logic [7:0]  OPC_PROG_SEC = 8'h42;
  localparam int          OPC_BITS     = 8;
  localparam int          ADDR_NARROW  = 24;
  localparam int          ADDR_WIDE    = 32;

endpackage

// File: rtl/secreg_spi_front.sv
module secreg_spi_front (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic di,
  output logic sck_rise,
  output logic cs_fall,
  output logic cs_rise,
  output logic di_q
);

  logic sck_q, sck_p, csn_q, csn_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sck_p <= 1'b0;
      csn_q <= 1'b1;
      csn_p <= 1'b1;
      di_q  <= 1'b0;
    end else begin
      sck_q <= sck;
      sck_p <= sck_q;
      csn_q <= csn;
      csn_p <= csn_q;
      di_q  <= di;
    end
  end

  assign sck_rise = sck_q & ~sck_p & ~csn_q;
  assign cs_fall  = ~csn_q & csn_p;
  assign cs_rise  = csn_q & ~csn_p;

endmodule

// File: rtl/secreg_cmd_decoder.sv
module secreg_cmd_decoder
  import secreg_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              di,
  input  logic              wel,
  input  logic              addr4b,
  input  logic [2:0]        lock,
  input  logic              busy,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [REG_AW-1:0] buf_idx,
  output logic [7:0]        buf_byte,
  output logic              commit_go,
  output logic [1:0]        commit_sel
);

  dec_state_t        state, n_state;
  logic [31:0]       shreg, n_shreg;
  logic [5:0]        bitcnt, n_bitcnt;
  logic              wide, n_wide;
  logic [REG_AW-1:0] ptr, n_ptr;
  logic [1:0]        sel, n_sel;
  logic              got, n_got;

  logic [31:0] shin;
  logic [31:0] addr_full;
  logic [5:0]  addr_last;
  logic [3:0]  field;
  logic [1:0]  sel_new;
  logic [3:0]  lock_pad;
  logic        addr_ok;
  logic        locked;

  assign shin      = {shreg[30:0], di};
  assign addr_last = wide ? 6'(ADDR_WIDE - 1) : 6'(ADDR_NARROW - 1);
  assign addr_full = wide ? shin : {8'h00, shin[23:0]};
  assign field     = addr_full[15:12];
  assign sel_new   = field[1:0] - 2'd1;
  assign lock_pad  = {1'b1, lock};
  assign addr_ok   = (addr_full[31:16] == 16'h0000) && (addr_full[11:8] == 4'h0) &&
                     (field != 4'h0) && (field <= 4'(NUM_SECREGS));
  assign locked    = lock_pad[sel_new];

  always_comb begin
    n_state   = state;
    n_shreg   = shreg;
    n_bitcnt  = bitcnt;
    n_wide    = wide;
    n_ptr     = ptr;
    n_sel     = sel;
    n_got     = got;
    buf_clr   = 1'b0;
    buf_we    = 1'b0;
    commit_go = 1'b0;

    if (cs_rise) begin
      if (state == ST_DATA && bitcnt[2:0] == 3'd0 && got) begin
        commit_go = 1'b1;
      end
      n_state = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cs_fall) begin
            n_bitcnt = 6'd0;
            n_shreg  = 32'h0;
            if (busy) begin
              n_state = ST_DROP;
            end else begin
              n_state = ST_OPC;
              buf_clr = 1'b1;
            end
          end
        end
        ST_OPC: begin
          if (sck_rise) begin
            n_shreg = shin;
            if (bitcnt == 6'(OPC_BITS - 1)) begin
              n_bitcnt = 6'd0;
              n_wide   = addr4b;
              n_state  = (shin[7:0] == OPC_PROG_SEC && wel) ? ST_ADDR : ST_DROP;
            end else begin
              n_bitcnt = bitcnt + 6'd1;
            end
          end
        end
        ST_ADDR: begin
          if (sck_rise) begin
            n_shreg = shin;
            if (bitcnt == addr_last) begin
              n_bitcnt = 6'd0;
              if (addr_ok && !locked) begin
                n_state = ST_DATA;
                n_ptr   = addr_full[REG_AW-1:0];
                n_sel   = sel_new;
                n_got   = 1'b0;
              end else begin
                n_state = ST_DROP;
              end
            end else begin
              n_bitcnt = bitcnt + 6'd1;
            end
          end
        end
        ST_DATA: begin
          if (sck_rise) begin
            n_shreg = shin;
            if (bitcnt[2:0] == 3'd7) begin
              buf_we   = 1'b1;
              n_bitcnt = 6'd0;
              n_ptr    = ptr + 1'b1;
              n_got    = 1'b1;
            end else begin
              n_bitcnt = bitcnt + 6'd1;
            end
          end
        end
        default: begin
          n_state = state;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      shreg  <= 32'h0;
      bitcnt <= 6'd0;
      wide   <= 1'b0;
      ptr    <= '0;
      sel    <= 2'd0;
      got    <= 1'b0;
    end else begin
      state  <= n_state;
      shreg  <= n_shreg;
      bitcnt <= n_bitcnt;
      wide   <= n_wide;
      ptr    <= n_ptr;
      sel    <= n_sel;
      got    <= n_got;
    end
  end

  assign buf_idx    = ptr;
  assign buf_byte   = shin[7:0];
  assign commit_sel = sel;

endmodule

// File: rtl/secreg_stage_buf.sv
module secreg_stage_buf #(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [REG_AW-1:0] wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic [REG_AW-1:0] rd_idx,
  output logic [7:0]        rd_byte,
  output logic              rd_vld
);

  localparam int DEPTH = 1 << REG_AW;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (we) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  assign rd_byte = mem[rd_idx];
  assign rd_vld  = vld[rd_idx];

endmodule

// File: rtl/secreg_store.sv
module secreg_store
  import secreg_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_go,
  input  logic [1:0]        commit_sel,
  input  logic [7:0]        stage_byte,
  input  logic              stage_vld,
  output logic [REG_AW-1:0] walk_idx,
  input  logic [1:0]        rd_sel,
  input  logic [REG_AW-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              wel_clr
);

  localparam int DEPTH = 1 << REG_AW;

  logic [7:0]        arr [NUM_SECREGS][DEPTH];
  logic              n_busy, n_wel_clr;
  logic [REG_AW-1:0] n_idx;
  logic [1:0]        tsel, n_tsel;
  logic              last;

  assign last = (walk_idx == REG_AW'(DEPTH - 1));

  always_comb begin
    n_busy    = busy;
    n_idx     = walk_idx;
    n_tsel    = tsel;
    n_wel_clr = 1'b0;
    if (busy) begin
      n_idx = walk_idx + 1'b1;
      if (last) begin
        n_busy    = 1'b0;
        n_wel_clr = 1'b1;
      end
    end else if (commit_go) begin
      n_busy = 1'b1;
      n_idx  = '0;
      n_tsel = commit_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      walk_idx <= '0;
      tsel     <= 2'd0;
      wel_clr  <= 1'b0;
    end else begin
      busy     <= n_busy;
      walk_idx <= n_idx;
      tsel     <= n_tsel;
      wel_clr  <= n_wel_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_SECREGS; r++) begin
        for (int b = 0; b < DEPTH; b++) begin
          arr[r][b] <= 8'hFF;
        end
      end
    end else if (busy && stage_vld) begin
      arr[tsel][walk_idx] <= arr[tsel][walk_idx] & stage_byte;
    end
  end

  assign rd_data = (32'(rd_sel) < NUM_SECREGS) ? arr[rd_sel][rd_idx] : 8'hFF;

endmodule

// File: rtl/secreg_prog_engine.sv
module secreg_prog_engine #(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_di,
  input  logic              wel,
  input  logic              addr4b,
  input  logic [2:0]        lock,
  input  logic [1:0]        rd_sel,
  input  logic [REG_AW-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              wel_clr
);

  logic              rst_meta, rst_sync_n;
  logic              sck_rise, cs_fall, cs_rise, di_q;
  logic              buf_clr, buf_we;
  logic [REG_AW-1:0] buf_idx, walk_idx;
  logic [7:0]        buf_byte, stage_byte;
  logic              stage_vld;
  logic              commit_go;
  logic [1:0]        commit_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  secreg_spi_front u_front (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sck      (spi_sck),
    .csn      (spi_csn),
    .di       (spi_di),
    .sck_rise (sck_rise),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .di_q     (di_q)
  );

  secreg_cmd_decoder #(.REG_AW(REG_AW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sck_rise   (sck_rise),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .di         (di_q),
    .wel        (wel),
    .addr4b     (addr4b),
    .lock       (lock),
    .busy       (busy),
    .buf_clr    (buf_clr),
    .buf_we     (buf_we),
    .buf_idx    (buf_idx),
    .buf_byte   (buf_byte),
    .commit_go  (commit_go),
    .commit_sel (commit_sel)
  );

  secreg_stage_buf #(.REG_AW(REG_AW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (buf_clr),
    .we      (buf_we),
    .wr_idx  (buf_idx),
    .wr_byte (buf_byte),
    .rd_idx  (walk_idx),
    .rd_byte (stage_byte),
    .rd_vld  (stage_vld)
  );

  secreg_store #(.REG_AW(REG_AW)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .commit_go  (commit_go),
    .commit_sel (commit_sel),
    .stage_byte (stage_byte),
    .stage_vld  (stage_vld),
    .walk_idx   (walk_idx),
    .rd_sel     (rd_sel),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .busy       (busy),
    .wel_clr    (wel_clr)
  );

endmodule

// File: rtl/secreg_prog_chk.sv
module secreg_prog_chk #(
  parameter int REG_AW = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_csn,
  input logic       busy,
  input logic       wel_clr,
  input logic       commit_go,
  input logic [1:0] commit_sel,
  input logic [2:0] lock
);

  localparam int DEPTH = 1 << REG_AW;
  localparam int CW    = REG_AW + 2;

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (busy) begin
      run_len <= run_len + 1'b1;
    end else begin
      run_len <= '0;
    end
  end

  assert_busy_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == CW'(DEPTH)));

  assert_wel_clr_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> (!busy && $past(busy)));

  assert_wel_clr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);

  assert_commit_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !lock[commit_sel]);

  assert_commit_sel_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> (commit_sel != 2'd3));

  assert_commit_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> spi_csn);

  assert_commit_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !busy);

endmodule

bind secreg_prog_engine secreg_prog_chk #(.REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_csn    (spi_csn),
  .busy       (busy),
  .wel_clr    (wel_clr),
  .commit_go  (commit_go),
  .commit_sel (commit_sel),
  .lock       (lock)
);

// File: tb/sim_secreg_prog_engine.sv
module sim_secreg_prog_engine;

  localparam int HALF = 3;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_sck, spi_csn, spi_di;
  logic       wel, addr4b;
  logic [2:0] lock;
  logic [1:0] rd_sel;
  logic [7:0] rd_idx;
  logic [7:0] rd_data;
  logic       busy, wel_clr;

  int n_chk = 0;
  int n_fail = 0;
  int busy_cyc = 0;
  int wclr_cnt = 0;
  bit idle_hi = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_mem [3][DEPTH];
  logic [7:0] dat [300];

  always #4 clk = ~clk;

  secreg_prog_engine u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_di(spi_di),
    .wel(wel), .addr4b(addr4b), .lock(lock), .rd_sel(rd_sel), .rd_idx(rd_idx),
    .rd_data(rd_data), .busy(busy), .wel_clr(wel_clr)
  );

  always @(posedge clk) begin
    if (busy === 1'b1) busy_cyc++;
    if (wel_clr === 1'b1) wclr_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic cmp_all(input string req);
    for (int r = 0; r < 3; r++) begin
      bit bad = 1'b0;
      int bad_i = 0;
      logic [7:0] bad_v = 8'h00;
      for (int i = 0; i < DEPTH; i++) begin
        @(negedge clk);
        rd_sel = 2'(r);
        rd_idx = 8'(i);
        #1;
        if (!bad && rd_data !== exp_mem[r][i]) begin
          bad = 1'b1;
          bad_i = i;
          bad_v = rd_data;
        end
      end
      chk(!bad, req, $sformatf("register %0d byte %0d", r, bad_i), int'(bad_v), int'(exp_mem[r][bad_i]));
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 300; i++) dat[i] = 8'((i * 29 + seed * 53 + 7) ^ (i >> 3));
  endtask

  task automatic shift_bit(input logic b);
    spi_sck = 1'b0;
    spi_di = b;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] opc, input logic [31:0] addr, input int alen,
                       input int nb, input int extra);
    spi_sck = idle_hi;
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8; i++) shift_bit(opc[7-i]);
    for (int i = 0; i < alen; i++) shift_bit(addr[alen-1-i]);
    for (int n = 0; n < nb; n++)
      for (int b = 0; b < 8; b++) shift_bit(dat[n][7-b]);
    for (int e = 0; e < extra; e++) shift_bit(e[0]);
    spi_sck = idle_hi;
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic bit will_take(input logic [7:0] opc, input logic [31:0] addr, input int alen,
                                   input int nb, input int extra);
    logic [3:0] f;
    bit hi_ok;
    f = addr[15:12];
    hi_ok = (alen == 24) ? (addr[23:16] == 8'h00) : (addr[31:16] == 16'h0000);
    if (opc != 8'h42 || !wel) return 1'b0;
    if (!hi_ok || addr[11:8] != 4'h0 || f < 4'd1 || f > 4'd3) return 1'b0;
    if (lock[f - 4'd1]) return 1'b0;
    if (nb < 1 || extra != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_apply(input logic [31:0] addr, input int nb);
    int r = int'(addr[15:12]) - 1;
    int first = (nb > DEPTH) ? nb - DEPTH : 0;
    for (int i = first; i < nb; i++)
      exp_mem[r][(int'(addr[7:0]) + i) % DEPTH] &= dat[i];
  endtask

  task automatic run(input logic [7:0] opc, input logic [31:0] addr, input int nb,
                     input int extra, input int seed, input string req);
    int alen = addr4b ? 32 : 24;
    bit take;
    fill(seed);
    take = will_take(opc, addr, alen, nb, extra);
    busy_cyc = 0;
    wclr_cnt = 0;
    frame(opc, addr, alen, nb, extra);
    repeat (300) @(negedge clk);
    chk(busy_cyc == (take ? DEPTH : 0), {req, " R11"}, "busy cycles", busy_cyc, take ? DEPTH : 0);
    chk(wclr_cnt == (take ? 1 : 0), {req, " R11"}, "wel_clr pulses", wclr_cnt, take ? 1 : 0);
    if (take) model_apply(addr, nb);
    cmp_all(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    spi_sck = 1'b0;
    spi_csn = 1'b1;
    spi_di = 1'b0;
    wel = 1'b1;
    addr4b = 1'b0;
    lock = 3'b000;
    rd_sel = 2'd0;
    rd_idx = 8'd0;
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < DEPTH; i++) exp_mem[r][i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(wel_clr === 1'b0, "R1", "wel_clr after reset", int'(wel_clr), 0);
    cmp_all("R1");

    // R2 R7: basic program, then overlapping AND
    run(8'h42, 32'h0000_1000, 4, 0, 1, "R2");
    run(8'h42, 32'h0000_1002, 4, 0, 2, "R7");
    // R2: wrong opcode
    run(8'h02, 32'h0000_1000, 4, 0, 3, "R2");
    // R3: write-enable clear
    wel = 1'b0;
    run(8'h42, 32'h0000_2000, 4, 0, 4, "R3");
    wel = 1'b1;
    // R4 R6: 32-bit address with wrap inside register
    addr4b = 1'b1;
    run(8'h42, 32'h0000_20F0, 20, 0, 5, "R4");
    // R5: bit above 15 set in 32-bit mode
    run(8'h42, 32'h0100_2000, 2, 0, 6, "R5");
    addr4b = 1'b0;
    // R5: invalid fields in 24-bit mode
    run(8'h42, 32'h0000_2100, 2, 0, 7, "R5");
    run(8'h42, 32'h0001_2000, 2, 0, 8, "R5");
    run(8'h42, 32'h0000_0010, 2, 0, 9, "R5");
    run(8'h42, 32'h0000_4010, 2, 0, 10, "R5");
    // R8: lock of register 2 blocks it, not register 0
    lock = 3'b100;
    run(8'h42, 32'h0000_3000, 3, 0, 11, "R8");
    run(8'h42, 32'h0000_1040, 3, 0, 12, "R8");
    lock = 3'b000;
    // R9: partial byte and zero bytes
    run(8'h42, 32'h0000_3000, 3, 5, 13, "R9");
    run(8'h42, 32'h0000_3000, 0, 0, 14, "R9");
    // R10: 300 bytes, only last 256 stay
    run(8'h42, 32'h0000_3010, 300, 0, 15, "R10");
    // R2: clock idle high framing
    idle_hi = 1'b1;
    run(8'h42, 32'h0000_2080, 5, 0, 16, "R2");
    idle_hi = 1'b0;
    // R6 R7: sweep over registers, start offsets and lengths
    for (int r = 1; r <= 3; r++)
      for (int k = 0; k < 4; k++)
        run(8'h42, (32'(r) << 12) | 32'(k * 67), 1 + k * 19, 0, 20 + r * 4 + k, "R6");

    // R12: second frame starts while busy
    begin
      logic [31:0] a_addr = 32'h0000_20C0;
      fill(40);
      busy_cyc = 0;
      wclr_cnt = 0;
      frame(8'h42, a_addr, 24, 3, 0);
      chk(busy === 1'b1, "R12", "busy after first frame", int'(busy), 1);
      frame(8'h42, 32'h0000_1000, 24, 3, 0);
      repeat (300) @(negedge clk);
      chk(busy_cyc == DEPTH, "R12", "busy cycles", busy_cyc, DEPTH);
      chk(wclr_cnt == 1, "R12", "wel_clr pulses", wclr_cnt, 1);
      model_apply(a_addr, 3);
      cmp_all("R12");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule